// File: doc/BRIEF.md
# Eight-Entry Circular Return-Address Stack

This block holds return addresses for a small processor core. When the core enters a subroutine or an interrupt handler, it pushes the current program address. When it executes a return, it pops the most recent address back into its program counter. The stack stores 11-bit addresses in eight slots. Reads come out in last-in, first-out order.

The stack never refuses a push and never flags an error. Its slots form a ring, and a pointer marks the top slot. A push past eight entries writes over the oldest slot, so the stack always keeps the eight most recent addresses. An occupancy count goes from 0 to 8 and saturates at both ends. The top-of-stack output comes straight from the stored state. The controlling logic can therefore read the address to be returned in the same cycle it raises the pop strobe.

Top module: `ret_stack`

## Requirements
- R1: After reset, `top_addr` is 0, `level` is 0, and every slot holds 0.
- R2: A push alone stores `push_addr` as the new top. One clock later, `top_addr` equals the pushed value and `level` rises by one if it was below 8.
- R3: A pop alone steps to the entry below. One clock later, `top_addr` shows the previously pushed address and `level` falls by one. Entries come back in reverse push order.
- R4: A push while `level` is 8 still stores the value and leaves `level` at 8. It overwrites the oldest entry, so ten pushes followed by eight pops return only the last eight values, newest first.
- R5: A pop while `level` is 0 leaves `level` at 0 and raises no error. The pointer still steps back one slot in ring order, and `top_addr` then shows whatever that slot holds.
- R6: A push and a pop in the same cycle replace the top entry with `push_addr` and leave `level` unchanged, including at 0 and at 8.
- R7: With neither strobe high, `top_addr` and `level` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Store `push_addr` on top |
| pop | input | 1 | Remove the top entry |
| push_addr | input | 11 | Return address to store |
| top_addr | output | 11 | Current top entry, read from stored state |
| level | output | 4 | Number of valid entries, 0 to 8 |

## Verification
Each strobe takes effect at one rising edge. Both `top_addr` and `level` show the result right after that edge, because `top_addr` comes combinationally from the pointer and the slots, with no register in between. The bench applies stimulus at a falling edge and lets exactly one rising edge pass. It then samples at the next falling edge, before it changes any input, so every check lands one cycle after its stimulus. To check the popped value itself, the bench reads `top_addr` in the cycle before each pop.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW = 11,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic [CW-1:0] level
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] tos;
  wire  [PW-1:0] tos_up = tos + 1'b1;
  wire  [PW-1:0] tos_dn = tos - 1'b1;

  assign top_addr = slot[tos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos   <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      case ({push, pop})
        2'b10: begin
          slot[tos_up] <= push_addr;
          tos          <= tos_up;
          if (level != FULL) level <= level + 1'b1;
        end
        2'b01: begin
          tos <= tos_dn;
          if (level != '0) level <= level - 1'b1;
        end
        2'b11: slot[tos] <= push_addr;
        default: ;
      endcase
    end
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> top_addr == $past(push_addr));
  p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level != FULL) |=> level == $past(level) + 1'b1);
  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level == FULL) |=> level == FULL);
  p_pop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level != '0) |=> level == $past(level) - 1'b1);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level == '0) |=> level == '0);
  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (top_addr == $past(push_addr) && $stable(level)));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> ($stable(top_addr) && $stable(level)));
endmodule

// File: tb/ret_stack_tb_top.sv
`timescale 1ns/1ps
module ret_stack_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, push = 1'b0, pop = 1'b0;
  logic [10:0] push_addr = '0;
  logic [10:0] top_addr;
  logic [3:0] level;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ret_stack dut_i (.clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
                   .push_addr(push_addr), .top_addr(top_addr), .level(level));

  // {push, pop, push_addr, expected top, expected level}
  localparam logic [27:0] VEC [8] = '{
    {1'b1, 1'b0, 11'h101, 11'h101, 4'd1},  // R2
    {1'b1, 1'b0, 11'h102, 11'h102, 4'd2},  // R2
    {1'b0, 1'b0, 11'h000, 11'h102, 4'd2},  // R7
    {1'b0, 1'b1, 11'h000, 11'h101, 4'd1},  // R3
    {1'b1, 1'b1, 11'h1AA, 11'h1AA, 4'd1},  // R6
    {1'b0, 1'b1, 11'h000, 11'h000, 4'd0},  // R3
    {1'b0, 1'b1, 11'h000, 11'h000, 4'd0},  // R5
    {1'b0, 1'b0, 11'h000, 11'h000, 4'd0}   // R7
  };

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic ps, input logic pp, input logic [10:0] d);
    push = ps; pop = pp; push_addr = d;
    @(posedge clk);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 top", top_addr, 0);
    chk("R1 level", level, 0);

    for (int k = 0; k < 8; k++) begin
      step(VEC[k][27], VEC[k][26], VEC[k][25:15]);
      chk($sformatf("R2/R3/R5/R6/R7 vec%0d top", k), top_addr, VEC[k][14:4]);
      chk($sformatf("R2/R3/R5/R6/R7 vec%0d level", k), level, VEC[k][3:0]);
    end

    // R4: ten pushes, oldest two lost
    do_reset();
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 1'b0, 11'h200 + 11'(k));
      chk("R4 push top", top_addr, 'h200 + k);
      chk("R4 push level", level, (k + 1 > 8) ? 8 : k + 1);
    end
    for (int k = 0; k < 8; k++) begin
      chk("R4 popped value", top_addr, 'h209 - k);
      step(1'b0, 1'b1, '0);
      chk("R3 pop level", level, 7 - k);
    end
    // R5: ring slot below now holds the overwriting value 0x209
    chk("R5 top after wrap", top_addr, 'h209);
    step(1'b0, 1'b1, '0);
    chk("R5 empty pop level", level, 0);
    // R6 at empty
    step(1'b1, 1'b1, 11'h055);
    chk("R6 empty swap top", top_addr, 'h055);
    chk("R6 empty swap level", level, 0);

    // R6 at full
    do_reset();
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 11'h300 + 11'(k));
    chk("R4 full level", level, 8);
    step(1'b1, 1'b1, 11'h3FF);
    chk("R6 full swap top", top_addr, 'h3FF);
    chk("R6 full swap level", level, 8);
    step(1'b0, 1'b1, '0);
    chk("R3 after swap top", top_addr, 'h306);
    chk("R3 after swap level", level, 7);

    // R1: reset mid-run
    do_reset();
    chk("R1 rerun top", top_addr, 0);
    chk("R1 rerun level", level, 0);
    step(1'b0, 1'b1, '0);
    chk("R1 cleared slot", top_addr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule